// File: doc/BRIEF.md
# Multi-Channel Key-Slot Stream Controller

This block is the control front end of a multi-channel block cipher engine that runs in a tweaked storage mode. Beats arrive one per clock. Each beat carries a profile code, a channel number, an algorithm select, a direction bit, a key-length bit, and four strobes: key load, tweak load, payload and end of packet. Beats with any profile code other than the tweaked-storage code are handed straight through to the output and marked as bypass traffic.

For its own profile the block keeps one key slot per channel, holding the key, its length and a written flag. A key beat fills a slot. A tweak beat opens a stream on a channel, using the tweak value carried in that beat and the key already held in the slot. Payload beats on an open channel leave through a registered cipher port, tagged with the slot key, the stream tweak and a start-of-stream marker. The beat that carries end of packet closes the stream. Misuse is reported on five single-cycle error pulses, and a beat that raises one of them changes no state.

Top module: `xts_keyslot_ctrl`

## Requirements
- R1: After synchronous reset every output is 0, every slot is unwritten and every channel is closed.
- R2: A valid beat whose profile code differs from 2 appears one cycle later with out_valid=1 and out_bypass=1. Its channel, direction, low 128 data bits, last flag and keep mask are copied, while key, tweak, key length and sos are 0. It changes no state and raises no error.
- R3: A key beat (key strobe 1, tweak strobe 0) on a closed, in-range channel stores the key in that channel's slot and opens no stream. A later payload beat on that channel is therefore rejected.
- R4: The key-length bit (1 = 256 bits, 0 = 128 bits, which keeps only the low 128 key bits) is sampled only on key beats. Its value on any other beat has no effect on the key length reported with payload.
- R5: With algorithm select 1 (the 128-bit-only cipher), a key beat that requests 256 bits raises err_key_size one cycle later and leaves the slot unchanged.
- R6: A tweak-only beat on a closed, in-range channel whose slot is written opens a stream with the tweak taken from data bits 127:0. If the slot was never written, the beat raises err_no_key and the channel stays closed.
- R7: A beat with both key and tweak strobes writes the slot first and then opens the stream with the new key. If the key write is rejected, no stream opens.
- R8: A key beat or a tweak beat on an open channel raises err_busy, leaves the slot and the stream unchanged, and opens no new stream.
- R9: A payload beat (data strobe only) on an open channel is output one cycle later with its channel, direction, slot key and key length, stream tweak, data and keep. sos=1 marks the first payload beat of the stream. The beat with the last flag closes the stream.
- R10: A payload beat on a closed channel raises err_no_stream and is dropped. Any key, tweak or payload beat whose channel number is not below the slot count raises err_bad_chan.
- R11: Error pulses are registered, last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present |
| in_profile | input | 3 | Profile code; 2 selects this block |
| in_chan | input | 10 | Channel / key slot number |
| in_alg | input | 1 | 1 = cipher limited to 128-bit keys |
| in_dir | input | 1 | 1 = encrypt, 0 = decrypt |
| in_key_long | input | 1 | Key length on key beats: 1 = 256 bit |
| in_key_en | input | 1 | Key load strobe |
| in_iv_en | input | 1 | Tweak load / stream start strobe |
| in_data_en | input | 1 | Payload strobe |
| in_last | input | 1 | End of packet |
| in_keep | input | 16 | Byte-valid mask of the beat |
| in_data | input | 256 | Key, tweak or payload field |
| out_valid | output | 1 | Output beat present |
| out_bypass | output | 1 | Output beat is pass-through traffic |
| out_chan | output | 10 | Channel of the output beat |
| out_dir | output | 1 | Direction of the output beat |
| out_key_long | output | 1 | Key length of the slot |
| out_key | output | 256 | Slot key |
| out_tweak | output | 128 | Stream tweak |
| out_data | output | 128 | Payload |
| out_sos | output | 1 | First payload beat of a stream |
| out_last | output | 1 | End of packet |
| out_keep | output | 16 | Byte-valid mask |
| err_busy | output | 1 | Key or start on an open channel |
| err_key_size | output | 1 | 256-bit key refused by the 128-bit-only cipher |
| err_no_key | output | 1 | Start on an unwritten slot |
| err_bad_chan | output | 1 | Channel number out of range |
| err_no_stream | output | 1 | Payload on a closed channel |

## Verification
The two functions that can share a cycle are the slot write and the stream start, both carried by a beat that raises the key and tweak strobes together. The bench drives such combined beats directly and also in a long random mix, both on fresh slots and on slots that already hold a different key. It covers the case where a 128-bit-only algorithm rejects the key, and the case where the channel is already open. The result is judged by the key, key length and tweak on the payload that follows, or by the single error pulse and the absence of an opened stream. A reference model that applies the write before the start predicts each outcome.

// File: rtl/xts_ks_pkg.sv
package xts_ks_pkg;

    parameter int CHAN_W      = 10;
    parameter int PROFILE_W   = 3;
    parameter int KEY_W       = 256;
    parameter int SHORT_KEY_W = 128;
    parameter int IV_W        = 128;
    parameter int DATA_W      = 128;
    parameter int KEEP_W      = DATA_W / 8;
    parameter int BUS_W       = KEY_W;

    parameter logic [PROFILE_W-1:0] PROFILE_TWEAKED = 3'd2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BYPASS,
        OP_KEY,
        OP_START,
        OP_KEY_START,
        OP_DATA
    } beat_op_e;

    typedef struct packed {
        logic              valid;
        logic              bypass;
        logic [CHAN_W-1:0] chan;
        logic              dir;
        logic              key_long;
        logic [KEY_W-1:0]  key;
        logic [IV_W-1:0]   tweak;
        logic [DATA_W-1:0] data;
        logic              sos;
        logic              last;
        logic [KEEP_W-1:0] keep;
    } out_beat_t;

    typedef struct packed {
        logic busy;
        logic key_size;
        logic no_key;
        logic bad_chan;
        logic no_stream;
    } err_t;

    function automatic logic [KEY_W-1:0] fit_key(input logic [KEY_W-1:0] raw,
                                                 input logic is_long);
        logic [KEY_W-1:0] mask;
        mask = is_long ? '1 : {{(KEY_W-SHORT_KEY_W){1'b0}}, {SHORT_KEY_W{1'b1}}};
        return raw & mask;
    endfunction

endpackage

// File: rtl/xts_ks_decode.sv
module xts_ks_decode
    import xts_ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 valid,
    input  logic [PROFILE_W-1:0] profile,
    input  logic [CHAN_W-1:0]    chan,
    input  logic                 key_en,
    input  logic                 iv_en,
    input  logic                 data_en,
    output beat_op_e             op,
    output logic                 in_range,
    output logic [SLOT_W-1:0]    idx
);

    always_comb begin
        if (!valid)                        op = OP_NONE;
        else if (profile != PROFILE_TWEAKED) op = OP_BYPASS;
        else if (key_en && iv_en)          op = OP_KEY_START;
        else if (key_en)                   op = OP_KEY;
        else if (iv_en)                    op = OP_START;
        else if (data_en)                  op = OP_DATA;
        else                               op = OP_NONE;
    end

    assign in_range = (chan < CHAN_W'(NUM_SLOTS));
    assign idx      = chan[SLOT_W-1:0];

endmodule

// File: rtl/xts_ks_key_store.sv
module xts_ks_key_store
    import xts_ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_idx,
    input  logic [KEY_W-1:0]     wr_key,
    input  logic                 wr_long,
    input  logic [NUM_SLOTS-1:0] lock,
    input  logic [SLOT_W-1:0]    rd_idx,
    output logic [KEY_W-1:0]     rd_key,
    output logic                 rd_long,
    output logic                 rd_prog
);

    logic [KEY_W-1:0]     key_q  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] long_q;
    logic [NUM_SLOTS-1:0] prog_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                key_q[s]  <= '0;
                long_q[s] <= 1'b0;
                prog_q[s] <= 1'b0;
            end else if (wr_en && (wr_idx == SLOT_W'(s))) begin
                key_q[s]  <= fit_key(wr_key, wr_long);
                long_q[s] <= wr_long;
                prog_q[s] <= 1'b1;
            end
        end

        // A slot whose stream is open must hold its key across the edge
        assert_locked_slot_R8: assert property (@(posedge clk) disable iff (rst)
            lock[s] |=> $stable(key_q[s]) && $stable(long_q[s]))
            else $error("locked slot %0d changed", s);
    end

    assign rd_key  = key_q[rd_idx];
    assign rd_long = long_q[rd_idx];
    assign rd_prog = prog_q[rd_idx];

endmodule

// File: rtl/xts_ks_stream_ctx.sv
module xts_ks_stream_ctx
    import xts_ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [SLOT_W-1:0]    start_idx,
    input  logic [IV_W-1:0]      start_tweak,
    input  logic                 data_fire,
    input  logic [SLOT_W-1:0]    data_idx,
    input  logic                 data_last,
    output logic [NUM_SLOTS-1:0] open_vec,
    output logic                 rd_first,
    output logic [IV_W-1:0]      rd_tweak
);

    logic [NUM_SLOTS-1:0] open_q;
    logic [NUM_SLOTS-1:0] first_q;
    logic [IV_W-1:0]      tweak_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ctx
        logic hit_start;
        logic hit_data;
        assign hit_start = start && (start_idx == SLOT_W'(s));
        assign hit_data  = data_fire && (data_idx == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[s]  <= 1'b0;
                first_q[s] <= 1'b0;
                tweak_q[s] <= '0;
            end else if (hit_start) begin
                open_q[s]  <= 1'b1;
                first_q[s] <= 1'b1;
                tweak_q[s] <= start_tweak;
            end else if (hit_data) begin
                first_q[s] <= 1'b0;
                if (data_last) open_q[s] <= 1'b0;
            end
        end

        // A channel only opens on a stream-start request for it
        assert_open_from_start_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(open_q[s]) |-> $past(start && start_idx == SLOT_W'(s)))
            else $error("channel %0d opened without start", s);
    end

    assign open_vec = open_q;
    assign rd_first = first_q[data_idx];
    assign rd_tweak = tweak_q[data_idx];

endmodule

// File: rtl/xts_keyslot_ctrl.sv
module xts_keyslot_ctrl
    import xts_ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [PROFILE_W-1:0] in_profile,
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic                 in_alg,
    input  logic                 in_dir,
    input  logic                 in_key_long,
    input  logic                 in_key_en,
    input  logic                 in_iv_en,
    input  logic                 in_data_en,
    input  logic                 in_last,
    input  logic [KEEP_W-1:0]    in_keep,
    input  logic [BUS_W-1:0]     in_data,
    output logic                 out_valid,
    output logic                 out_bypass,
    output logic [CHAN_W-1:0]    out_chan,
    output logic                 out_dir,
    output logic                 out_key_long,
    output logic [KEY_W-1:0]     out_key,
    output logic [IV_W-1:0]      out_tweak,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_sos,
    output logic                 out_last,
    output logic [KEEP_W-1:0]    out_keep,
    output logic                 err_busy,
    output logic                 err_key_size,
    output logic                 err_no_key,
    output logic                 err_bad_chan,
    output logic                 err_no_stream
);

    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    beat_op_e             op;
    logic                 in_range;
    logic [SLOT_W-1:0]    idx;
    logic [NUM_SLOTS-1:0] open_vec;
    logic [KEY_W-1:0]     rd_key;
    logic                 rd_long;
    logic                 rd_prog;
    logic                 rd_first;
    logic [IV_W-1:0]      rd_tweak;

    xts_ks_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
        .valid    (in_valid),
        .profile  (in_profile),
        .chan     (in_chan),
        .key_en   (in_key_en),
        .iv_en    (in_iv_en),
        .data_en  (in_data_en),
        .op       (op),
        .in_range (in_range),
        .idx      (idx)
    );

    // Per-beat classification
    logic busy, key_req, start_req, uses_slot;
    logic key_busy, key_size_bad, key_wr;
    logic start_busy, start_base, start_no_key, start_go;
    logic data_req, data_fire, data_orphan;

    assign busy      = in_range && open_vec[idx];
    assign key_req   = (op == OP_KEY) || (op == OP_KEY_START);
    assign start_req = (op == OP_START) || (op == OP_KEY_START);
    assign data_req  = (op == OP_DATA);
    assign uses_slot = key_req || start_req || data_req;

    assign key_busy     = key_req && in_range && busy;
    assign key_size_bad = key_req && in_range && !busy && in_alg && in_key_long;
    assign key_wr       = key_req && in_range && !busy && !key_size_bad;

    assign start_busy   = (op == OP_START) && busy;
    assign start_base   = start_req && in_range && !busy && !key_size_bad;
    assign start_no_key = start_base && !(rd_prog || key_wr);
    assign start_go     = start_base && (rd_prog || key_wr);

    assign data_fire    = data_req && busy;
    assign data_orphan  = data_req && in_range && !busy;

    xts_ks_key_store #(.NUM_SLOTS(NUM_SLOTS)) u_keys (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (key_wr),
        .wr_idx  (idx),
        .wr_key  (in_data),
        .wr_long (in_key_long),
        .lock    (open_vec),
        .rd_idx  (idx),
        .rd_key  (rd_key),
        .rd_long (rd_long),
        .rd_prog (rd_prog)
    );

    xts_ks_stream_ctx #(.NUM_SLOTS(NUM_SLOTS)) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .start       (start_go),
        .start_idx   (idx),
        .start_tweak (in_data[IV_W-1:0]),
        .data_fire   (data_fire),
        .data_idx    (idx),
        .data_last   (in_last),
        .open_vec    (open_vec),
        .rd_first    (rd_first),
        .rd_tweak    (rd_tweak)
    );

    // Output beat and error assembly
    out_beat_t beat_d, beat_q;
    err_t      err_d, err_q;

    always_comb begin
        beat_d = '0;
        if (op == OP_BYPASS) begin
            beat_d.valid  = 1'b1;
            beat_d.bypass = 1'b1;
            beat_d.chan   = in_chan;
            beat_d.dir    = in_dir;
            beat_d.data   = in_data[DATA_W-1:0];
            beat_d.last   = in_last;
            beat_d.keep   = in_keep;
        end else if (data_fire) begin
            beat_d.valid    = 1'b1;
            beat_d.chan     = in_chan;
            beat_d.dir      = in_dir;
            beat_d.key_long = rd_long;
            beat_d.key      = rd_key;
            beat_d.tweak    = rd_tweak;
            beat_d.data     = in_data[DATA_W-1:0];
            beat_d.sos      = rd_first;
            beat_d.last     = in_last;
            beat_d.keep     = in_keep;
        end
    end

    always_comb begin
        err_d           = '0;
        err_d.bad_chan  = uses_slot && !in_range;
        err_d.busy      = key_busy || start_busy;
        err_d.key_size  = key_size_bad;
        err_d.no_key    = start_no_key;
        err_d.no_stream = data_orphan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            err_q  <= '0;
        end else begin
            beat_q <= beat_d;
            err_q  <= err_d;
        end
    end

    assign out_valid     = beat_q.valid;
    assign out_bypass    = beat_q.bypass;
    assign out_chan      = beat_q.chan;
    assign out_dir       = beat_q.dir;
    assign out_key_long  = beat_q.key_long;
    assign out_key       = beat_q.key;
    assign out_tweak     = beat_q.tweak;
    assign out_data      = beat_q.data;
    assign out_sos       = beat_q.sos;
    assign out_last      = beat_q.last;
    assign out_keep      = beat_q.keep;
    assign err_busy      = err_q.busy;
    assign err_key_size  = err_q.key_size;
    assign err_no_key    = err_q.no_key;
    assign err_bad_chan  = err_q.bad_chan;
    assign err_no_stream = err_q.no_stream;

    assert_err_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_busy, err_key_size, err_no_key, err_bad_chan, err_no_stream}))
        else $error("several error pulses at once");

    assert_key_size_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) && err_key_size |-> $past(in_alg && in_key_long && in_key_en))
        else $error("key size error without a long key request");

    assert_bypass_clean_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_bypass |-> !out_sos && !out_key_long && (out_key == '0) && (out_tweak == '0))
        else $error("bypass beat carries cipher context");

    assert_payload_has_stream_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_bypass |-> !(err_no_stream || err_bad_chan))
        else $error("payload emitted alongside rejection");

endmodule

// File: tb/xts_keyslot_ctrl_tb.sv
`timescale 1ns/1ps
module xts_keyslot_ctrl_tb;
    import xts_ks_pkg::*;

    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic                 in_valid, in_alg, in_dir, in_key_long;
    logic                 in_key_en, in_iv_en, in_data_en, in_last;
    logic [PROFILE_W-1:0] in_profile;
    logic [CHAN_W-1:0]    in_chan;
    logic [KEEP_W-1:0]    in_keep;
    logic [BUS_W-1:0]     in_data;

    logic                 out_valid, out_bypass, out_dir, out_key_long, out_sos, out_last;
    logic [CHAN_W-1:0]    out_chan;
    logic [KEY_W-1:0]     out_key;
    logic [IV_W-1:0]      out_tweak;
    logic [DATA_W-1:0]    out_data;
    logic [KEEP_W-1:0]    out_keep;
    logic err_busy, err_key_size, err_no_key, err_bad_chan, err_no_stream;

    xts_keyslot_ctrl #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_profile(in_profile),
        .in_chan(in_chan), .in_alg(in_alg), .in_dir(in_dir), .in_key_long(in_key_long),
        .in_key_en(in_key_en), .in_iv_en(in_iv_en), .in_data_en(in_data_en),
        .in_last(in_last), .in_keep(in_keep), .in_data(in_data),
        .out_valid(out_valid), .out_bypass(out_bypass), .out_chan(out_chan),
        .out_dir(out_dir), .out_key_long(out_key_long), .out_key(out_key),
        .out_tweak(out_tweak), .out_data(out_data), .out_sos(out_sos),
        .out_last(out_last), .out_keep(out_keep), .err_busy(err_busy),
        .err_key_size(err_key_size), .err_no_key(err_no_key),
        .err_bad_chan(err_bad_chan), .err_no_stream(err_no_stream)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [KEY_W-1:0] m_key   [NS];
    logic             m_long  [NS];
    logic             m_prog  [NS];
    logic             m_open  [NS];
    logic             m_first [NS];
    logic [IV_W-1:0]  m_tweak [NS];

    // Expected outputs for the beat in flight
    logic             e_valid, e_bypass, e_dir, e_long, e_sos, e_last;
    logic [CHAN_W-1:0] e_chan;
    logic [KEY_W-1:0] e_key;
    logic [IV_W-1:0]  e_tweak;
    logic [DATA_W-1:0] e_data;
    logic [KEEP_W-1:0] e_keep;
    logic e_busy, e_ksize, e_nokey, e_bad, e_nostream;

    task automatic chk(input string tag, input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_key[s] = '0; m_long[s] = 0; m_prog[s] = 0;
            m_open[s] = 0; m_first[s] = 0; m_tweak[s] = '0;
        end
    endtask

    task automatic predict();
        int  s;
        bit  inr, ok_key;
        {e_valid, e_bypass, e_dir, e_long, e_sos, e_last} = '0;
        e_chan = '0; e_key = '0; e_tweak = '0; e_data = '0; e_keep = '0;
        {e_busy, e_ksize, e_nokey, e_bad, e_nostream} = '0;
        if (!in_valid) return;
        if (in_profile != PROFILE_TWEAKED) begin
            e_valid = 1; e_bypass = 1; e_chan = in_chan; e_dir = in_dir;
            e_data = in_data[DATA_W-1:0]; e_last = in_last; e_keep = in_keep;
            return;
        end
        inr = (in_chan < NS);
        s = inr ? int'(in_chan) : 0;
        if (in_key_en || in_iv_en) begin
            if (!inr) begin e_bad = 1; return; end
            if (m_open[s]) begin e_busy = 1; return; end
            ok_key = 1;
            if (in_key_en) begin
                if (in_alg && in_key_long) begin
                    e_ksize = 1; ok_key = 0;
                end else begin
                    m_key[s]  = in_key_long ? in_data : {128'd0, in_data[127:0]};
                    m_long[s] = in_key_long;
                    m_prog[s] = 1;
                end
            end
            if (in_iv_en && ok_key) begin
                if (!m_prog[s]) e_nokey = 1;
                else begin
                    m_open[s] = 1; m_first[s] = 1; m_tweak[s] = in_data[IV_W-1:0];
                end
            end
        end else if (in_data_en) begin
            if (!inr) begin e_bad = 1; return; end
            if (!m_open[s]) begin e_nostream = 1; return; end
            e_valid = 1; e_chan = in_chan; e_dir = in_dir; e_long = m_long[s];
            e_key = m_key[s]; e_tweak = m_tweak[s]; e_data = in_data[DATA_W-1:0];
            e_sos = m_first[s]; e_last = in_last; e_keep = in_keep;
            m_first[s] = 0;
            if (in_last) m_open[s] = 0;
        end
    endtask

    task automatic compare();
        chk("R2 R9 out_valid", KEY_W'(out_valid), KEY_W'(e_valid));
        chk("R2 out_bypass", KEY_W'(out_bypass), KEY_W'(e_bypass));
        chk("R9 out_chan", KEY_W'(out_chan), KEY_W'(e_chan));
        chk("R9 out_dir", KEY_W'(out_dir), KEY_W'(e_dir));
        chk("R4 out_key_long", KEY_W'(out_key_long), KEY_W'(e_long));
        chk("R3 R7 out_key", out_key, e_key);
        chk("R6 out_tweak", KEY_W'(out_tweak), KEY_W'(e_tweak));
        chk("R9 out_data", KEY_W'(out_data), KEY_W'(e_data));
        chk("R9 out_sos", KEY_W'(out_sos), KEY_W'(e_sos));
        chk("R9 out_last", KEY_W'(out_last), KEY_W'(e_last));
        chk("R9 out_keep", KEY_W'(out_keep), KEY_W'(e_keep));
        chk("R8 err_busy", KEY_W'(err_busy), KEY_W'(e_busy));
        chk("R5 err_key_size", KEY_W'(err_key_size), KEY_W'(e_ksize));
        chk("R6 err_no_key", KEY_W'(err_no_key), KEY_W'(e_nokey));
        chk("R10 err_bad_chan", KEY_W'(err_bad_chan), KEY_W'(e_bad));
        chk("R10 err_no_stream", KEY_W'(err_no_stream), KEY_W'(e_nostream));
        chk("R11 one error", KEY_W'($countones({err_busy, err_key_size, err_no_key,
                                                 err_bad_chan, err_no_stream}) > 1), '0);
    endtask

    // Drive one beat (called just after a falling edge), check it one cycle later
    task automatic beat(input logic v, input logic [2:0] prof, input int ch,
                        input logic alg, input logic dir, input logic klong,
                        input logic ken, input logic iven, input logic den,
                        input logic last, input logic [KEEP_W-1:0] keep,
                        input logic [BUS_W-1:0] data);
        in_valid = v; in_profile = prof; in_chan = CHAN_W'(ch); in_alg = alg;
        in_dir = dir; in_key_long = klong; in_key_en = ken; in_iv_en = iven;
        in_data_en = den; in_last = last; in_keep = keep; in_data = data;
        predict();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [BUS_W-1:0] rnd_bus();
        logic [BUS_W-1:0] r;
        for (int i = 0; i < BUS_W / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    localparam logic [2:0] X = 3'd2;

    initial begin
        rst = 1'b1;
        in_valid = 0; in_profile = '0; in_chan = '0; in_alg = 0; in_dir = 0;
        in_key_long = 0; in_key_en = 0; in_iv_en = 0; in_data_en = 0;
        in_last = 0; in_keep = '0; in_data = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 out_valid after reset", KEY_W'(out_valid), '0);
        chk("R1 errors after reset", KEY_W'({err_busy, err_key_size, err_no_key,
                                             err_bad_chan, err_no_stream}), '0);
        chk("R1 out_key after reset", out_key, '0);

        // R1/R6: fresh slot is unwritten -> start rejected, payload rejected
        beat(1, X, 0, 0, 1, 0, 0, 1, 0, 0, '0, 256'h1111);
        beat(1, X, 0, 0, 1, 0, 0, 0, 1, 0, 16'hffff, 256'h2222);
        // R3: key-only beat (128-bit), no stream opened
        beat(1, X, 0, 0, 1, 0, 1, 0, 0, 0, '0, {128'hdead, 128'hcafe_0000_beef});
        beat(1, X, 0, 0, 1, 0, 0, 0, 1, 0, 16'hffff, 256'h3333);
        // R6/R4: start with key-length bit set on a non-key beat (ignored)
        beat(1, X, 0, 0, 1, 1, 0, 1, 0, 0, '0, 256'h7777_abcd);
        beat(1, X, 0, 0, 1, 1, 0, 0, 1, 0, 16'hffff, 256'h4444);
        beat(1, X, 0, 0, 0, 1, 0, 0, 1, 0, 16'hffff, 256'h5555);
        beat(1, X, 0, 0, 1, 0, 0, 0, 1, 1, 16'h001f, 256'h6666);
        // R10: after last, payload rejected
        beat(1, X, 0, 0, 1, 0, 0, 0, 1, 0, 16'hffff, 256'h6667);
        // R5: 256-bit key refused by 128-bit-only algorithm; slot stays unwritten
        beat(1, X, 1, 1, 1, 1, 1, 0, 0, 0, '0, rnd_bus());
        beat(1, X, 1, 0, 1, 0, 0, 1, 0, 0, '0, 256'h99);
        // R7: combined write+start refused by key size -> no stream
        beat(1, X, 1, 1, 1, 1, 1, 1, 0, 0, '0, rnd_bus());
        beat(1, X, 1, 0, 1, 0, 0, 0, 1, 0, 16'hffff, 256'h98);
        // R7: combined write+start with 256-bit key
        beat(1, X, 2, 0, 1, 1, 1, 1, 0, 0, '0, rnd_bus());
        beat(1, X, 2, 0, 1, 0, 0, 0, 1, 0, 16'h00ff, rnd_bus());
        // R8: key and start on open channel rejected, old key kept
        beat(1, X, 2, 0, 1, 0, 1, 0, 0, 0, '0, rnd_bus());
        beat(1, X, 2, 0, 1, 0, 0, 1, 0, 0, '0, rnd_bus());
        beat(1, X, 2, 0, 1, 0, 1, 1, 0, 0, '0, rnd_bus());
        // R2: bypass beat in the middle of a stream
        beat(1, 3'd5, 2, 0, 1, 1, 1, 1, 1, 1, 16'h0f0f, rnd_bus());
        beat(1, X, 2, 0, 1, 0, 0, 0, 1, 1, 16'h0001, rnd_bus());
        // R7: combined beat rewrites a slot that held a different key
        beat(1, X, 2, 0, 1, 0, 1, 1, 0, 0, '0, rnd_bus());
        beat(1, X, 2, 0, 1, 0, 0, 0, 1, 1, 16'hffff, rnd_bus());
        // R10: out-of-range channel
        beat(1, X, 7, 0, 1, 0, 1, 0, 0, 0, '0, rnd_bus());
        beat(1, X, 4, 0, 1, 0, 0, 1, 0, 0, '0, rnd_bus());
        beat(1, X, 9, 0, 1, 0, 0, 0, 1, 0, 16'hffff, rnd_bus());
        beat(0, X, 0, 0, 0, 0, 1, 1, 1, 1, '0, rnd_bus());

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r, kind;
            logic ken, iven, den;
            r = $urandom_range(0, 99);
            kind = $urandom_range(0, 99);
            ken  = (kind < 15) || (kind >= 90);
            iven = (kind >= 15 && kind < 30) || (kind >= 85);
            den  = $urandom_range(0, 1) == 1 || (kind >= 30 && kind < 85);
            beat($urandom_range(0, 9) != 0, (r < 88) ? X : 3'($urandom_range(0, 7)),
                 $urandom_range(0, NS), $urandom_range(0, 3) == 0,
                 1'($urandom), 1'($urandom), ken, iven, den,
                 $urandom_range(0, 4) == 0, KEEP_W'($urandom), rnd_bus());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule